// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the per-processor timer of a local interrupt controller. Software writes a 32-bit initial count through a small synchronous register port. The count then runs down at the input clock rate, divided by a power of two that a divide code selects. A timer control register holds an interrupt vector, a mask bit and a periodic-mode bit. The current count can be read back at any time.

When the count runs out, the block raises a single-cycle expiry pulse carrying the control register's vector. In one-shot mode this happens once. In periodic mode the count reloads and the pulse repeats. A count of zero is treated as stopped in both modes.

A synchronous INIT request puts every register it holds back to its default value and cancels any expiry that is pending. The same port also holds a few plain controller registers (task priority, spurious vector, logical destination, destination format, error status, command) so that INIT restores them as well.

Top module: `lapic_timer`

## Requirements
- R1: After reset or INIT the registers read as follows: task priority (address 0, 8 bits) 0x00, spurious vector (1, 8 bits) 0xFF, logical destination (2, 8 bits) 0x00, destination format (3, 4 bits) 0xF, error status (4, 8 bits) 0x00, command (5, 32 bits) 0, timer control (6) 0x0001_0000, initial count (7) 0, current count (8) 0, divide code (9, 3 bits) 0. Unmapped addresses read 0. The timer control register holds the vector in bits 7:0, the mask in bit 16 and periodic mode in bit 17.
- R2: A divide code c below 7 sets the tick rate to one tick every 2^(c+1) clocks. Code 7 gives one tick per clock. Ticks are counted in whole multiples of that prescale, measured from the clock edge that loaded the count.
- R3: In one-shot mode with an initial count N > 0, the current count reads N minus the elapsed ticks until it reaches 0, and then stays at 0. Exactly one expiry pulse occurs, at elapsed tick N+1.
- R4: In periodic mode with N > 0, one period lasts N+1 ticks. The current count reads N - (ticks mod (N+1)). An expiry pulse occurs at every nonzero multiple of N+1 ticks.
- R5: An initial count of 0 never produces an expiry pulse, in either mode.
- R6: While the mask bit is set, no expiry pulse is produced, but counting continues. A one-shot expiry that falls while the mask is set is lost. A periodic timer that is unmasked again pulses at its next period boundary.
- R7: The expiry pulse lasts one clock cycle, and during it the vector output equals bits 7:0 of the timer control register.
- R8: Writing the initial count restarts the count and the prescaler from that edge. If that write falls in the same cycle as an expiry, the load wins and no pulse is produced.
- R9: A read returns its data one cycle after the read strobe, and rd_data holds that value until the next read. Writes to the current count register (address 8) are ignored.
- R10: INIT clears the count and cancels any pending expiry. It takes priority over a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Synchronous INIT request, restores register defaults |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, registered |
| tmr_fire | output | 1 | One-cycle expiry pulse |
| tmr_vector | output | 8 | Vector carried with the expiry pulse |

## Verification
The case that matters most is a rewrite of the initial count landing on the same clock edge as an expiry. The bench provokes it with a one-tick-per-clock one-shot timer loaded with 3, then rewrites the count exactly four edges after the load. A control run that skips the rewrite shows that this edge really does expire. The bench judges the result with a behavioural model that tracks elapsed clocks and ticks since the load: it expects no pulse on the colliding edge and a fresh count afterwards. The model also covers an INIT request that coincides with a register write.

// File: rtl/lapic_timer_pkg.sv
// Package: shared register map and field positions for the local timer.
// Assumes a 4-bit register address and a 32-bit data path.
package lapic_timer_pkg;
    localparam int ADDR_W       = 4;
    localparam int PRI_W        = 8;
    localparam int FMT_W        = 4;
    localparam int LVT_MASK_BIT = 16;
    localparam int LVT_PER_BIT  = 17;

    typedef enum logic [ADDR_W-1:0] {
        RA_TPR   = 4'd0,
        RA_SPUR  = 4'd1,
        RA_LDEST = 4'd2,
        RA_DFMT  = 4'd3,
        RA_ESR   = 4'd4,
        RA_CMD   = 4'd5,
        RA_LVT   = 4'd6,
        RA_INIT  = 4'd7,
        RA_CUR   = 4'd8,
        RA_DIV   = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/lapic_timer_regs.sv
// Module: register file with INIT defaults and a registered read port.
// Assumes a single write and a single read per cycle. INIT beats a write.
module lapic_timer_regs
    import lapic_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] cur_count,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] init_cnt,
    output logic [VEC_W-1:0]  lvt_vec,
    output logic              lvt_mask,
    output logic              lvt_per,
    output logic [DIV_W-1:0]  div_code,
    output logic              load_cnt
);
    logic [PRI_W-1:0]  tpr_q, spur_q, ldest_q, esr_q;
    logic [FMT_W-1:0]  dfmt_q;
    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] rd_next;

    // Purpose: flag a count load that INIT does not override.
    assign load_cnt = wr_en && !init_req && (wr_addr == RA_INIT);

    // Purpose: hold the registers and apply reset, INIT or a write.
    always_ff @(posedge clk) begin
        if (!rst_n || init_req) begin
            tpr_q    <= '0;
            spur_q   <= '1;
            ldest_q  <= '0;
            dfmt_q   <= '1;
            esr_q    <= '0;
            cmd_q    <= '0;
            lvt_vec  <= '0;
            lvt_mask <= 1'b1;
            lvt_per  <= 1'b0;
            init_cnt <= '0;
            div_code <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_TPR:   tpr_q   <= wr_data[PRI_W-1:0];
                RA_SPUR:  spur_q  <= wr_data[PRI_W-1:0];
                RA_LDEST: ldest_q <= wr_data[PRI_W-1:0];
                RA_DFMT:  dfmt_q  <= wr_data[FMT_W-1:0];
                RA_ESR:   esr_q   <= wr_data[PRI_W-1:0];
                RA_CMD:   cmd_q   <= wr_data;
                RA_LVT: begin
                    lvt_vec  <= wr_data[VEC_W-1:0];
                    lvt_mask <= wr_data[LVT_MASK_BIT];
                    lvt_per  <= wr_data[LVT_PER_BIT];
                end
                RA_INIT:  init_cnt <= wr_data;
                RA_DIV:   div_code <= wr_data[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    // Purpose: select the read value for the addressed register.
    always_comb begin
        rd_next = '0;
        case (reg_addr_e'(rd_addr))
            RA_TPR:   rd_next[PRI_W-1:0] = tpr_q;
            RA_SPUR:  rd_next[PRI_W-1:0] = spur_q;
            RA_LDEST: rd_next[PRI_W-1:0] = ldest_q;
            RA_DFMT:  rd_next[FMT_W-1:0] = dfmt_q;
            RA_ESR:   rd_next[PRI_W-1:0] = esr_q;
            RA_CMD:   rd_next = cmd_q;
            RA_LVT: begin
                rd_next[VEC_W-1:0]    = lvt_vec;
                rd_next[LVT_MASK_BIT] = lvt_mask;
                rd_next[LVT_PER_BIT]  = lvt_per;
            end
            RA_INIT:  rd_next = init_cnt;
            RA_CUR:   rd_next = cur_count;
            RA_DIV:   rd_next[DIV_W-1:0] = div_code;
            default:  rd_next = '0;
        endcase
    end

    // Purpose: register the read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/lapic_timer_prescale.sv
// Module: power-of-two prescaler. It pulses 'tick' once every 2^shift clocks,
// counted from the last clear. Divide code all-ones means shift 0; any other
// code c means shift c+1.
module lapic_timer_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [DIV_W-1:0] shift;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] low_mask;

    // Purpose: decode the divide code and form the mask of the low bits.
    always_comb begin
        shift    = (div_code == '1) ? '0 : div_code + DIV_W'(1);
        low_mask = (PRE_W'(1) << shift) - PRE_W'(1);
        tick     = ((pre_q & low_mask) == low_mask);
    end

    // Purpose: count clocks since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre_q <= '0;
        else               pre_q <= pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/lapic_timer_count.sv
// Module: the down counter and expiry pulse. A load beats a tick. A one-shot
// count fires once on the tick after it reaches zero. A periodic count fires
// and reloads on that tick. A zero load never fires.
module lapic_timer_count #(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] init_cnt,
    input  logic              tick,
    input  logic              per_mode,
    input  logic              masked,
    input  logic [VEC_W-1:0]  vec,
    output logic [DATA_W-1:0] cur,
    output logic              fire,
    output logic [VEC_W-1:0]  fire_vec
);
    logic armed;

    // Purpose: step the count, reload or disarm it, and raise the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || init_req) begin
            cur      <= '0;
            armed    <= 1'b0;
            fire     <= 1'b0;
            fire_vec <= '0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                cur   <= load_val;
                armed <= (load_val != '0);
            end else if (tick) begin
                if (cur != '0) begin
                    cur <= cur - DATA_W'(1);
                end else if (per_mode) begin
                    cur <= init_cnt;
                    if (init_cnt != '0) begin
                        fire     <= !masked;
                        fire_vec <= vec;
                    end
                end else if (armed) begin
                    armed    <= 1'b0;
                    fire     <= !masked;
                    fire_vec <= vec;
                end
            end
        end
    end
endmodule

// File: rtl/lapic_timer.sv
// Module: top level of the local interrupt controller timer. It joins the
// register file, the prescaler and the down counter. The clock and reset are
// synchronous. Register access goes through a one-cycle read/write port.
module lapic_timer
    import lapic_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tmr_fire,
    output logic [VEC_W-1:0]  tmr_vector
);
    logic [DATA_W-1:0] init_cnt, cur_count;
    logic [VEC_W-1:0]  lvt_vec;
    logic              lvt_mask, lvt_per, load_cnt, tick;
    logic [DIV_W-1:0]  div_code;

    lapic_timer_regs #(.DATA_W(DATA_W), .VEC_W(VEC_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .init_req(init_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .cur_count(cur_count),
        .rd_data(rd_data), .init_cnt(init_cnt), .lvt_vec(lvt_vec),
        .lvt_mask(lvt_mask), .lvt_per(lvt_per), .div_code(div_code),
        .load_cnt(load_cnt)
    );

    lapic_timer_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(load_cnt || init_req),
        .div_code(div_code), .tick(tick)
    );

    lapic_timer_count #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .init_req(init_req),
        .load(load_cnt), .load_val(wr_data), .init_cnt(init_cnt),
        .tick(tick), .per_mode(lvt_per), .masked(lvt_mask), .vec(lvt_vec),
        .cur(cur_count), .fire(tmr_fire), .fire_vec(tmr_vector)
    );
endmodule

// File: rtl/lapic_timer_chk.sv
// Module: property checker for lapic_timer. It is bound into the top level
// and watches the pulse, the load strobe and the counter state.
module lapic_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_req,
    input logic              tmr_fire,
    input logic              ld_pulse,
    input logic              lvt_mask,
    input logic [DATA_W-1:0] cnt_cur,
    input logic [DATA_W-1:0] cnt_init
);
    // R7
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_fire |=> !tmr_fire);
    // R6
    pulse_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_fire |-> !$past(lvt_mask));
    // R5
    pulse_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_fire |-> ($past(cnt_init) != '0));
    // R3
    pulse_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_fire |-> ($past(cnt_cur) == '0));
    // R8
    load_blocks_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pulse |=> !tmr_fire);
    // R10
    init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> (!tmr_fire && cnt_cur == '0));
endmodule

bind lapic_timer lapic_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .tmr_fire(tmr_fire),
    .ld_pulse(load_cnt), .lvt_mask(lvt_mask), .cnt_cur(cur_count),
    .cnt_init(init_cnt)
);

// File: tb/lapic_timer_tb.sv
// Bench: drives register traffic and compares the block against a behavioural
// model that counts elapsed clocks and ticks since the load.
module lapic_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, init_req = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tmr_fire;
    logic [7:0]  tmr_vector;

    int    total = 0, bad = 0;
    bit    done = 0;
    string tag = "R1";

    lapic_timer u_dut (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .tmr_fire(tmr_fire),
        .tmr_vector(tmr_vector)
    );

    always #5 clk = ~clk;

    // ---- behavioural model ----
    int     m_tpr, m_spur, m_ldest, m_dfmt, m_esr, m_div, m_vec, m_fvec;
    longint m_cmd, m_init, m_c, m_d, m_rd;
    bit     m_mask, m_per, m_fire;

    function automatic longint m_cur();
        if (m_per) return m_init - (m_d % (m_init + 1));
        return (m_d < m_init) ? m_init - m_d : 0;
    endfunction

    function automatic longint m_read(int a);
        case (a)
            0: return m_tpr;   1: return m_spur;  2: return m_ldest;
            3: return m_dfmt;  4: return m_esr;   5: return m_cmd;
            6: return (longint'(m_per) << 17) | (longint'(m_mask) << 16) | m_vec;
            7: return m_init;  8: return m_cur(); 9: return m_div;
            default: return 0;
        endcase
    endfunction

    task automatic m_defaults();
        m_tpr = 0; m_spur = 'hFF; m_ldest = 0; m_dfmt = 'hF; m_esr = 0;
        m_cmd = 0; m_vec = 0; m_mask = 1; m_per = 0; m_init = 0; m_div = 0;
        m_c = 0; m_d = 0; m_fire = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_defaults(); m_rd = 0; m_fvec = 0;
        end else begin
            if (rd_en) m_rd = m_read(int'(rd_addr));
            if (init_req) m_defaults();
            else begin
                int sh;
                sh = (m_div == 7) ? 0 : m_div + 1;
                m_fire = 0;
                if (wr_en && wr_addr == 7) begin
                    m_c = 0; m_d = 0;
                end else begin
                    m_c++;
                    if (m_c % (longint'(1) << sh) == 0) begin
                        m_d++;
                        if (m_init != 0 &&
                            ((m_per && (m_d % (m_init + 1)) == 0) ||
                             (!m_per && m_d == m_init + 1))) begin
                            m_fire = !m_mask;
                            if (!m_mask) m_fvec = m_vec;
                        end
                    end
                end
                if (wr_en) case (wr_addr)
                    0: m_tpr = wr_data[7:0];   1: m_spur = wr_data[7:0];
                    2: m_ldest = wr_data[7:0]; 3: m_dfmt = wr_data[3:0];
                    4: m_esr = wr_data[7:0];   5: m_cmd = wr_data;
                    6: begin m_vec = wr_data[7:0]; m_mask = wr_data[16];
                             m_per = wr_data[17]; end
                    7: m_init = wr_data;       9: m_div = wr_data[2:0];
                    default: ;
                endcase
            end
        end
    end

    // Compare the outputs against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (tmr_fire !== m_fire) begin
                bad++;
                $display("FAIL %s: tmr_fire=%0b expected=%0b at %0t", tag, tmr_fire, m_fire, $time);
            end
            total++;
            if (m_fire && tmr_vector !== m_fvec[7:0]) begin
                bad++;
                $display("FAIL %s: tmr_vector=%0h expected=%0h", tag, tmr_vector, m_fvec);
            end
            total++;
            if (rd_data !== m_rd[31:0]) begin
                bad++;
                $display("FAIL %s: rd_data=%0h expected=%0h at %0t", tag, rd_data, m_rd[31:0], $time);
            end
        end
    end

    // ---- stimulus tasks; each starts and ends at a falling edge ----
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        wr_en = 1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(int a);
        rd_en = 1; rd_addr = 4'(a);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic rd_all();
        for (int a = 0; a < 11; a++) rd(a);
    endtask

    task automatic pulse_init(bit with_wr);
        init_req = 1;
        if (with_wr) begin wr_en = 1; wr_addr = 4'd0; wr_data = 32'h55; end
        @(negedge clk);
        init_req = 0; wr_en = 0;
    endtask

    // Run n cycles and read the current count on every second cycle.
    task automatic run_rd(int n);
        for (int i = 0; i < n; i++) begin
            if (i % 2 == 0) rd(8); else idle(1);
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: cycles=200000 expected=completion");
            finish_up();
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        tag = "R1"; rd_all();
        wr(0, 32'h12); wr(1, 32'h34); wr(2, 32'h56); wr(3, 32'h7); wr(4, 32'h9);
        wr(5, 32'hDEADBEEF); wr(6, 32'h3_00AA); wr(7, 32'd40); wr(9, 32'd5);
        rd_all();
        pulse_init(0);
        rd_all();

        tag = "R2";
        for (int code = 0; code < 8; code++) begin
            wr(9, 32'(code)); wr(6, 32'h2_0040 + 32'(code)); wr(7, 32'd3);
            idle((8 << ((code == 7) ? 0 : code + 1)) + 4);
        end

        tag = "R3";
        wr(9, 32'd7); wr(6, 32'h0_0021); wr(7, 32'd5); run_rd(20);
        wr(9, 32'd1); wr(7, 32'd6); run_rd(70);

        tag = "R4";
        wr(9, 32'd0); wr(6, 32'h2_0022); wr(7, 32'd4); run_rd(40);
        wr(9, 32'd7); wr(7, 32'd1); run_rd(12);

        tag = "R5";
        wr(6, 32'h2_0023); wr(7, 32'd0); run_rd(12);
        wr(6, 32'h0_0023); wr(7, 32'd0); run_rd(12);

        tag = "R6";
        wr(6, 32'h3_0024); wr(7, 32'd3); run_rd(10);
        wr(6, 32'h2_0024); idle(12);
        wr(6, 32'h1_0025); wr(7, 32'd3); idle(8);
        wr(6, 32'h0_0025); run_rd(10);

        tag = "R7";
        wr(6, 32'h2_00A5); wr(7, 32'd2); idle(8);
        wr(6, 32'h2_003C); idle(8);

        tag = "R8";
        wr(6, 32'h0_0031); wr(7, 32'd3); idle(6);
        wr(7, 32'd3); idle(3); wr(7, 32'd2); run_rd(10);
        wr(6, 32'h2_0032); wr(7, 32'd2); idle(2); wr(7, 32'd4); idle(2);
        wr(7, 32'd4); run_rd(12);

        tag = "R9";
        wr(8, 32'h1234); rd(8); rd(7); idle(3); rd(15); rd(12); idle(2);

        tag = "R10";
        wr(6, 32'h2_0041); wr(7, 32'd3); idle(2);
        pulse_init(1); rd(0); rd(8); idle(10); rd_all();
        wr(9, 32'd7); wr(6, 32'h0_0042); wr(7, 32'd2); idle(1);
        pulse_init(0); idle(6); rd(6);
        idle(2);
        finish_up();
    end
endmodule